// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 64 interrupt sources, organised as two banks of 32, and presents one interrupt request line to a processor. A rising edge on a source input is captured as a pending bit. The pending bit stays set until software acknowledges it by writing a one to its bit position. Each source has its own enable bit and a 3-bit priority value. Among the sources that are both enabled and pending, an arbiter picks one winner.

Software reads an entry register to learn which source won. The entry value is a programmable base plus four times (winning index + 1). When no source qualifies, the entry reads as the bare base value. With a base of zero, an entry of zero therefore means "nothing to service", and the index is recovered as (entry >> 2) − 1. The register interface is a plain 32-bit bus. It has a byte address, a write strobe and write data, and read data that follows the address in the same cycle.

Top module: `prio_vec_intc`

## Requirements
- R1: A rising edge of source k (low in one sampled cycle, high in the next) sets pending bit k at that clock edge. The bit stays set until it is acknowledged. Sources 0..31 read as bits 0..31 at offset 0x08, and sources 32..63 read as bits 0..31 at offset 0x0C.
- R2: Writing to 0x08 or 0x0C clears every pending bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. If a new edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R3: Enable bits sit at 0x18 (sources 0..31) and 0x1C (sources 32..63), and they read back as written. They are all 0 after reset. A source whose enable bit is 0 takes no part in arbitration. Clearing an enable removes that source from the entry value from the cycle after the write.
- R4: Eight priority registers sit at 0x30 + 4·r. Source k uses register k/8, bits [4·(k mod 8)+2 : 4·(k mod 8)]. Bit 4·(k mod 8)+3 is not stored and reads as 0.
- R5: The winner is the enabled pending source with the numerically smallest priority value. Among equal priority values, the smallest source index wins.
- R6: Offset 0x14 reads base + ((winner + 1) << 2), or base when there is no winner. The base is read/write at 0x24. Writes to 0x14 change nothing.
- R7: irq_o is registered. It is 1 in the cycle after a cycle in which some source is enabled and pending, and 0 in the cycle after a cycle in which none is.
- R8: Several kinds of offset read 0 and ignore writes: any offset that is not a multiple of four, any offset not listed in R1 to R6, and the offsets 0x00, 0x04 and 0x20 (the controller has only the immediate-mask mode).
- R9: After reset, all pending bits, enables, priorities and the base are 0, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Interrupt source inputs, edge-sensitive |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong pending, enable or priority state shows up at the entry offset within one cycle of the access that caused it. It appears either as a wrong winning index or as a base-only value while a request is live. irq_o lags the same state by one further cycle. The sweeps therefore drive every source alone through the arbiter and then many mixed patterns, and compare the entry value with an arithmetic model after each change. A stale or lost pending bit also shows directly in the pending readback. The edge-and-clear collision and the one-cycle irq latency are checked at their exact cycles.

// File: rtl/pvi_pkg.sv
package pvi_pkg;

    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int PRIO_W    = 3;
    localparam int NIB_W     = 4;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int PER_REG   = DATA_W / NIB_W;
    localparam int NUM_PREG  = NUM_SRC / PER_REG;
    localparam int SEL_W     = 4;

    // Offsets software decodes
    localparam logic [ADDR_W-1:0] OFS_PEND0 = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ENTRY = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_EN0   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_BASE  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_PRIO0 = 8'h30;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
        prio_t            prio;
    } win_t;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PEND,
        REG_EN,
        REG_ENTRY,
        REG_BASE,
        REG_PRIO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [SEL_W-1:0] sel;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        int   off;
        off    = int'(a);
        d.kind = REG_NONE;
        d.sel  = '0;
        if (a[1:0] == 2'b00) begin
            if (off >= int'(OFS_PEND0) && off < int'(OFS_PEND0) + 4 * NUM_BANKS) begin
                d.kind = REG_PEND;
                d.sel  = SEL_W'((off - int'(OFS_PEND0)) >> 2);
            end else if (off >= int'(OFS_EN0) && off < int'(OFS_EN0) + 4 * NUM_BANKS) begin
                d.kind = REG_EN;
                d.sel  = SEL_W'((off - int'(OFS_EN0)) >> 2);
            end else if (a == OFS_ENTRY) begin
                d.kind = REG_ENTRY;
            end else if (a == OFS_BASE) begin
                d.kind = REG_BASE;
            end else if (off >= int'(OFS_PRIO0) && off < int'(OFS_PRIO0) + 4 * NUM_PREG) begin
                d.kind = REG_PRIO;
                d.sel  = SEL_W'((off - int'(OFS_PRIO0)) >> 2);
            end
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] entry_word(input logic [DATA_W-1:0] base,
                                                     input win_t w);
        logic [DATA_W-1:0] ofs;
        ofs = w.found ? DATA_W'((int'(w.idx) + 1) << 2) : '0;
        return base + ofs;
    endfunction

endpackage

// File: rtl/pvi_pend_bank.sv
module pvi_pend_bank
    import pvi_pkg::*;
#(
    parameter int W = BANK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] src_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] rise;

    assign rise = src_i & ~src_q;

    always_ff @(posedge clk) begin
        src_q <= src_i;
        if (rst) begin
            pend_q <= '0;
        end else begin
            // a fresh edge overrides a simultaneous acknowledge
            pend_q <= (pend_q & ~clr_i) | rise;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/pvi_arbiter.sv
module pvi_arbiter
    import pvi_pkg::*;
#(
    parameter int N   = NUM_SRC,
    parameter int GRP = PER_REG
) (
    input  logic [N-1:0]             req_i,
    input  logic [N-1:0][PRIO_W-1:0] prio_i,
    output win_t                     win_o
);

    localparam int NGRP = N / GRP;

    win_t grp_win [NGRP];

    // first level: best request inside each group, scanned upward so ties keep the lower index
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_comb begin
            win_t w;
            w = '0;
            for (int i = 0; i < GRP; i++) begin
                if (req_i[g*GRP+i] && (!w.found || prio_i[g*GRP+i] < w.prio)) begin
                    w.found = 1'b1;
                    w.idx   = IDX_W'(g*GRP+i);
                    w.prio  = prio_i[g*GRP+i];
                end
            end
            grp_win[g] = w;
        end
    end

    // second level: strict compare keeps the lower group on equal priority
    always_comb begin
        win_t best;
        best = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_win[g].found && (!best.found || grp_win[g].prio < best.prio)) begin
                best = grp_win[g];
            end
        end
        win_o = best;
    end

endmodule

// File: rtl/pvi_regfile.sv
module pvi_regfile
    import pvi_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [NUM_SRC-1:0]           pend_i,
    input  logic [DATA_W-1:0]            entry_i,
    output logic [NUM_SRC-1:0]           en_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
    output logic [DATA_W-1:0]            base_o,
    output logic [NUM_SRC-1:0]           clr_o,
    output logic [DATA_W-1:0]            rdata_o
);

    dec_t                          dec;
    logic [NUM_BANKS-1:0][BANK_W-1:0] en_q;
    logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_q;
    logic [DATA_W-1:0]                base_q;

    assign dec = decode(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            prio_q <= '0;
            base_q <= '0;
        end else if (bus_wr) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (dec.kind == REG_EN && int'(dec.sel) == b) begin
                    en_q[b] <= bus_wdata;
                end
            end
            for (int k = 0; k < NUM_SRC; k++) begin
                if (dec.kind == REG_PRIO && int'(dec.sel) == k / PER_REG) begin
                    prio_q[k] <= bus_wdata[(k % PER_REG)*NIB_W +: PRIO_W];
                end
            end
            if (dec.kind == REG_BASE) begin
                base_q <= bus_wdata;
            end
        end
    end

    // acknowledge mask, one pulse per write
    always_comb begin
        clr_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_wr && dec.kind == REG_PEND && int'(dec.sel) == b) begin
                clr_o[b*BANK_W +: BANK_W] = bus_wdata;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (dec.kind)
            REG_PEND: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(dec.sel) == b) rdata_o = pend_i[b*BANK_W +: BANK_W];
                end
            end
            REG_EN: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(dec.sel) == b) rdata_o = en_q[b];
                end
            end
            REG_ENTRY: rdata_o = entry_i;
            REG_BASE:  rdata_o = base_q;
            REG_PRIO: begin
                for (int k = 0; k < NUM_SRC; k++) begin
                    if (int'(dec.sel) == k / PER_REG) begin
                        rdata_o[(k % PER_REG)*NIB_W +: PRIO_W] = prio_q[k];
                    end
                end
            end
            default: rdata_o = '0;
        endcase
    end

    assign en_o   = en_q;
    assign prio_o = prio_q;
    assign base_o = base_q;

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pvi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [63:0]        src_i,
    input  logic [7:0]         bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o
);

    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0]             en;
    logic [NUM_SRC-1:0]             clr;
    logic [NUM_SRC-1:0]             req;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [DATA_W-1:0]              base;
    logic [DATA_W-1:0]              entry;
    win_t                           win;
    logic                           irq_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pvi_pend_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .src_i  (src_i[b*BANK_W +: BANK_W]),
            .clr_i  (clr[b*BANK_W +: BANK_W]),
            .pend_o (pend[b*BANK_W +: BANK_W])
        );
    end

    assign req = pend & en;

    pvi_arbiter #(.N(NUM_SRC), .GRP(PER_REG)) u_arb (
        .req_i  (req),
        .prio_i (prio),
        .win_o  (win)
    );

    assign entry = entry_word(base, win);

    pvi_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pend_i    (pend),
        .entry_i   (entry),
        .en_o      (en),
        .prio_o    (prio),
        .base_o    (base),
        .clr_o     (clr),
        .rdata_o   (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |req;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/pvi_chk.sv
module pvi_chk
    import pvi_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic [63:0]                  src_i,
    input logic [7:0]                   bus_addr,
    input logic                         bus_wr,
    input logic [31:0]                  bus_wdata,
    input logic                         irq_o,
    input logic [NUM_SRC-1:0]           pend,
    input logic [NUM_SRC-1:0]           en,
    input logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input win_t                         win
);

    logic [63:0] src_q;
    logic        better;

    always_ff @(posedge clk) src_q <= src_i;

    always_comb begin
        better = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (pend[k] && en[k]) begin
                if (!win.found || prio[k] < win.prio ||
                    (prio[k] == win.prio && k < int'(win.idx))) better = 1'b1;
            end
        end
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        // R1
        edge_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(src_i[k]) |=> pend[k]);
    end

    // R2
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_PEND0) |=>
        ((pend[31:0] & $past(bus_wdata & ~(src_i[31:0] & ~src_q[31:0]))) == '0));

    // R2
    zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_PEND0) |=>
        (($past(pend[31:0] & ~bus_wdata) & ~pend[31:0]) == '0));

    // R3
    en_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (en == '0));

    // R5
    win_live_chk: assert property (@(posedge clk) disable iff (rst)
        win.found |-> (pend[win.idx] && en[win.idx]));

    // R5
    win_best_chk: assert property (@(posedge clk) disable iff (rst)
        !better);

    // R7
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(win.found)));

endmodule

bind prio_vec_intc pvi_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .pend      (pend),
    .en        (en),
    .prio      (prio),
    .win       (win)
);

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] m_pend = '0;
    logic [63:0] m_en   = '0;
    int          m_prio [64];
    logic [31:0] m_base = '0;
    int unsigned seed   = 32'h1234_5678;

    always #4 clk = ~clk;

    prio_vec_intc uut (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    function automatic int unsigned lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [63:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
        src = '0;
        m_pend = m_pend | v;
    endtask

    task automatic ack_all();
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        m_pend = '0;
    endtask

    task automatic set_en(input logic [63:0] v);
        wr(8'h18, v[31:0]);
        wr(8'h1C, v[63:32]);
        m_en = v;
    endtask

    function automatic logic [31:0] exp_prio_reg(input int r);
        logic [31:0] v;
        v = '0;
        for (int n = 0; n < 8; n++) v = v | (32'(m_prio[r*8+n]) << (4*n));
        return v;
    endfunction

    function automatic logic [31:0] exp_entry();
        int best;
        best = -1;
        for (int k = 0; k < 64; k++) begin
            if (m_pend[k] && m_en[k]) begin
                if (best < 0 || m_prio[k] < m_prio[best]) best = k;
            end
        end
        if (best < 0) return m_base;
        return m_base + 32'((best + 1) << 2);
    endfunction

    function automatic bit is_mapped(input int a);
        if (a == 8'h08 || a == 8'h0C || a == 8'h14 || a == 8'h18 || a == 8'h1C || a == 8'h24)
            return 1'b1;
        if (a >= 8'h30 && a <= 8'h4C && (a % 4) == 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_state(input string req);
        logic [31:0] d;
        rd(8'h08, d); check(req, "pend0", d, m_pend[31:0]);
        rd(8'h0C, d); check(req, "pend1", d, m_pend[63:32]);
        rd(8'h18, d); check(req, "en0", d, m_en[31:0]);
        rd(8'h1C, d); check(req, "en1", d, m_en[63:32]);
        rd(8'h24, d); check(req, "base", d, m_base);
        for (int r = 0; r < 8; r++) begin
            rd(8'(8'h30 + 4*r), d); check(req, "prio", d, exp_prio_reg(r));
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R7 actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        for (int k = 0; k < 64; k++) m_prio[k] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check("R9", "irq after reset", 32'(irq), 32'h0);
        check_state("R9");
        rd(8'h14, d); check("R9", "entry after reset", d, 32'h0);

        // R4 upper nibble bit not stored
        wr(8'h30, 32'hFFFF_FFFF);
        for (int n = 0; n < 8; n++) m_prio[n] = 7;
        rd(8'h30, d); check("R4", "prio all ones", d, 32'h7777_7777);
        // R4 sweep of all priority registers
        for (int r = 0; r < 8; r++) begin
            v = lcg();
            wr(8'(8'h30 + 4*r), v);
            for (int n = 0; n < 8; n++) m_prio[r*8+n] = int'((v >> (4*n)) & 32'h7);
        end
        for (int r = 0; r < 8; r++) begin
            rd(8'(8'h30 + 4*r), d); check("R4", "prio readback", d, exp_prio_reg(r));
        end

        // R1 each source alone, enables all off: pending set, no request (R3)
        for (int k = 0; k < 64; k++) begin
            pulse(64'h1 << k);
            rd(k < 32 ? 8'h08 : 8'h0C, d);
            check("R1", "pend single", d, k < 32 ? m_pend[31:0] : m_pend[63:32]);
            ack_all();
        end
        pulse(64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h14, d); check("R3", "masked entry", d, 32'h0);
        check("R3", "masked irq", 32'(irq), 32'h0);
        ack_all();

        // R3 enables read back
        set_en(64'hA5A5_0F0F_1234_8001);
        rd(8'h18, d); check("R3", "en0", d, m_en[31:0]);
        rd(8'h1C, d); check("R3", "en1", d, m_en[63:32]);

        // R6 single winner sweep with nonzero base
        m_base = 32'h0000_4000;
        wr(8'h24, m_base);
        set_en('1);
        for (int k = 0; k < 64; k++) begin
            pulse(64'h1 << k);
            rd(8'h14, d); check("R6", "entry single", d, m_base + 32'((k + 1) << 2));
            check("R7", "irq single", 32'(irq), 32'h1);
            ack_all();
        end

        // R6 zero base: entry zero when idle, index recoverable
        m_base = '0;
        wr(8'h24, 32'h0);
        rd(8'h14, d); check("R6", "idle entry", d, 32'h0);
        pulse(64'h1 << 45);
        rd(8'h14, d); check("R6", "recovered index", (d >> 2) - 32'h1, 32'd45);
        // R6 entry is read-only
        wr(8'h14, 32'hDEAD_BEEF);
        rd(8'h14, d); check("R6", "entry after write", d, exp_entry());
        rd(8'h24, d); check("R6", "base after entry write", d, 32'h0);
        ack_all();

        // R5 ties: all priorities equal, lowest index wins
        for (int r = 0; r < 8; r++) wr(8'(8'h30 + 4*r), 32'h3333_3333);
        for (int k = 0; k < 64; k++) m_prio[k] = 3;
        pulse(64'h8000_0100_0040_0000);
        rd(8'h14, d); check("R5", "tie lowest index", d, 32'((22 + 1) << 2));
        ack_all();

        // R5 mixed patterns
        m_base = 32'h0010_0000;
        wr(8'h24, m_base);
        for (int t = 0; t < 40; t++) begin
            for (int r = 0; r < 8; r++) begin
                v = lcg();
                wr(8'(8'h30 + 4*r), v);
                for (int n = 0; n < 8; n++) m_prio[r*8+n] = int'((v >> (4*n)) & 32'h7);
            end
            set_en({lcg(), lcg()} | {lcg(), lcg()});
            pulse({lcg(), lcg()} & {lcg(), lcg()});
            rd(8'h14, d); check("R5", "entry mixed", d, exp_entry());
            check("R7", "irq mixed", 32'(irq), 32'(exp_entry() != m_base));
            rd(8'h08, d); check("R1", "pend0 mixed", d, m_pend[31:0]);
            rd(8'h0C, d); check("R1", "pend1 mixed", d, m_pend[63:32]);
            ack_all();
        end

        // R3 disabling the winner takes it out at once
        for (int k = 0; k < 64; k++) m_prio[k] = 0;
        for (int r = 0; r < 8; r++) wr(8'(8'h30 + 4*r), 32'h0);
        set_en('1);
        pulse(64'h0000_0000_0000_0030);
        rd(8'h14, d); check("R3", "entry before disable", d, exp_entry());
        set_en(~64'h10);
        rd(8'h14, d); check("R3", "entry after disable", d, m_base + 32'(6 << 2));
        set_en(~64'h30);
        rd(8'h14, d); check("R3", "entry all masked", d, m_base);
        ack_all();
        set_en('1);

        // R2 write zero keeps, write one clears, edge beats clear
        pulse(64'h0000_0000_0000_0068);
        @(negedge clk);
        src       = 64'h8;
        bus_addr  = 8'h08;
        bus_wdata = 32'h28;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        src    = '0;
        m_pend = 64'h48;
        rd(8'h08, d); check("R2", "edge vs clear", d, 32'h48);
        ack_all();

        // R7 latency: irq one cycle after pending
        @(negedge clk);
        src = 64'h80;
        @(negedge clk);
        src = '0;
        check("R7", "irq not yet", 32'(irq), 32'h0);
        @(negedge clk);
        check("R7", "irq asserted", 32'(irq), 32'h1);
        @(negedge clk);
        bus_addr  = 8'h08;
        bus_wdata = 32'h80;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7", "irq held one cycle", 32'(irq), 32'h1);
        @(negedge clk);
        check("R7", "irq dropped", 32'(irq), 32'h0);
        m_pend = '0;

        // R8 unmapped, unaligned, fault-path and control offsets
        pulse(64'h0000_0001_0000_0002);
        for (int a = 0; a < 256; a++) begin
            if (!is_mapped(a)) wr(8'(a), 32'hFFFF_FFFF);
        end
        for (int a = 0; a < 256; a += 3) begin
            if (!is_mapped(a)) begin
                rd(8'(a), d); check("R8", "unmapped read", d, 32'h0);
            end
        end
        rd(8'h00, d); check("R8", "fault offset 0", d, 32'h0);
        rd(8'h20, d); check("R8", "control offset", d, 32'h0);
        check_state("R8");
        rd(8'h14, d); check("R8", "entry intact", d, exp_entry());

        finish_run();
    end

endmodule